// File: doc/BRIEF.md
# Packed Integer Vector ALU

This block is a single-cycle packed integer execution unit for a 128-bit vector datapath. Each accepted request carries two vector operands, a 4-bit operation code, a 2-bit element-size select and an 8-bit immediate. The block returns one vector result, registered, together with a flag that marks requests it cannot carry out.

The operand is treated as a row of independent lanes whose width is 8, 16, 32 or 64 bits. The block adds and subtracts lane by lane. It applies the four bitwise operations to the whole vector. An equality compare writes an all-ones or all-zeros mask into each lane. Bit shifts inside each lane take their count from the immediate. The whole vector can also be moved left or right by a number of bytes, with zeros shifted in. Lane 0 always occupies the least significant bits.

Operation codes: 0 add, 1 subtract, 2 AND, 3 OR, 4 XOR, 5 AND-NOT (~a & b), 6 equality compare, 7 lane logical left shift, 8 lane logical right shift, 9 lane arithmetic right shift, 10 vector byte shift left, 11 vector byte shift right. Codes 12 to 15 are undefined. Size select: 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = 64-bit lanes.

Top module: `psimd_alu`

## Requirements
- R1: Opcode 0 adds a and b separately in every lane of the selected width, modulo 2^width. No carry passes from one lane into the next.
- R2: Opcode 1 computes a minus b separately in every lane of the selected width, modulo 2^width. No borrow passes from one lane into the next.
- R3: Opcodes 2, 3, 4 and 5 compute a&b, a|b, a^b and ~a&b over all 128 bits, whatever the size select. XOR of identical operands gives all zeros.
- R4: Opcode 6 sets every bit of a lane to one when the lanes of a and b are equal, and sets every bit of that lane to zero otherwise.
- R5: Opcodes 7 and 8 shift each 16-, 32- or 64-bit lane left or right by the immediate and fill with zeros. A count at or above the lane width gives a zero lane.
- R6: Opcode 9 shifts each 16- or 32-bit lane right by the immediate and fills with the lane's sign bit. A count at or above the lane width gives a lane filled with the sign bit.
- R7: The following requests are illegal: opcode 7 or 8 with 8-bit lanes, opcode 9 with 8-bit or 64-bit lanes, and opcodes 12 to 15. An illegal request yields illegal = 1 and an all-zero result. A legal request yields illegal = 0.
- R8: Opcodes 10 and 11 shift the whole 128-bit operand a left or right by the immediate counted in bytes, and fill the vacated bytes with zeros. An immediate of 16 or more gives zero.
- R9: out_valid is high in the cycle after in_valid was high and low otherwise. result and illegal change only on an accepted request and otherwise hold their values.
- R10: While reset is asserted, out_valid, result and illegal are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present this cycle |
| op | input | 4 | Operation code |
| esize | input | 2 | Lane width select |
| imm | input | 8 | Shift count in bits or bytes |
| src_a | input | 128 | First operand |
| src_b | input | 128 | Second operand |
| out_valid | output | 1 | Result present this cycle |
| result | output | 128 | Registered result vector |
| illegal | output | 1 | Registered illegal-request flag |

## Verification
Every result, and its illegal flag, becomes due on the first rising edge after the request is driven. out_valid rises on that same edge. The driver applies each request at a falling edge and pushes the bench's own expected value into a queue. The monitor samples at the next falling edge, half a cycle after the capturing edge, and pops exactly one entry for each cycle in which out_valid is high. On idle cycles the monitor checks that the last result and flag are still held.

// File: rtl/psimd_pkg.sv
package psimd_pkg;

   typedef enum logic [3:0] {
      OP_ADD   = 4'd0,
      OP_SUB   = 4'd1,
      OP_AND   = 4'd2,
      OP_OR    = 4'd3,
      OP_XOR   = 4'd4,
      OP_ANDN  = 4'd5,
      OP_CMPEQ = 4'd6,
      OP_SHL   = 4'd7,
      OP_SHR   = 4'd8,
      OP_SAR   = 4'd9,
      OP_BSL   = 4'd10,
      OP_BSR   = 4'd11
   } op_e;

   typedef enum logic [1:0] {
      SZ_8  = 2'd0,
      SZ_16 = 2'd1,
      SZ_32 = 2'd2,
      SZ_64 = 2'd3
   } esize_e;

   typedef enum logic [1:0] {
      SK_LEFT  = 2'd0,
      SK_RIGHT = 2'd1,
      SK_ARITH = 2'd2
   } shkind_e;

endpackage

// File: rtl/psimd_lane_arith.sv
module psimd_lane_arith #(
   parameter int W = 128
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         sub,
   input  logic [1:0]   sz,
   output logic [W-1:0] sum_o,
   output logic [W-1:0] eq_o
);
   localparam int NSZ = 4;

   logic [NSZ-1:0][W-1:0] sums;
   logic [NSZ-1:0][W-1:0] eqs;

   for (genvar gi = 0; gi < NSZ; gi++) begin : g_size
      localparam int EW = 8 << gi;
      localparam int NL = W / EW;
      for (genvar li = 0; li < NL; li++) begin : g_lane
         logic [EW-1:0] la, lb;
         assign la = a[li*EW +: EW];
         assign lb = b[li*EW +: EW];
         assign sums[gi][li*EW +: EW] = sub ? (la - lb) : (la + lb);
         assign eqs[gi][li*EW +: EW]  = {EW{la == lb}};
      end
   end

   assign sum_o = sums[sz];
   assign eq_o  = eqs[sz];

endmodule

// File: rtl/psimd_lane_shift.sv
module psimd_lane_shift #(
   parameter int W     = 128,
   parameter int IMM_W = 8
) (
   input  logic [W-1:0]     a,
   input  logic [IMM_W-1:0] cnt,
   input  logic [1:0]       sz,
   input  logic [1:0]       kind,
   output logic [W-1:0]     res
);
   import psimd_pkg::*;

   localparam int NSZ = 4;

   logic [NSZ-1:0][W-1:0] by_size;

   for (genvar gi = 0; gi < NSZ; gi++) begin : g_size
      if (gi == 0) begin : g_none
         assign by_size[gi] = '0;
      end else begin : g_lanes
         localparam int EW = 8 << gi;
         localparam int NL = W / EW;
         logic big;
         assign big = ({1'b0, cnt} >= (IMM_W+1)'(EW));
         for (genvar li = 0; li < NL; li++) begin : g_lane
            logic [EW-1:0] la, lsh, lsr, lsa;
            assign la  = a[li*EW +: EW];
            assign lsh = big ? '0 : (la << cnt);
            assign lsr = big ? '0 : (la >> cnt);
            assign lsa = big ? {EW{la[EW-1]}} : EW'($signed(la) >>> cnt);
            assign by_size[gi][li*EW +: EW] =
               (kind == SK_LEFT)  ? lsh :
               (kind == SK_RIGHT) ? lsr : lsa;
         end
      end
   end

   assign res = by_size[sz];

endmodule

// File: rtl/psimd_byte_shift.sv
module psimd_byte_shift #(
   parameter int W     = 128,
   parameter int IMM_W = 8
) (
   input  logic [W-1:0]     a,
   input  logic [IMM_W-1:0] cnt,
   input  logic             right,
   output logic [W-1:0]     res
);
   localparam int NB = W / 8;

   logic              big;
   logic [IMM_W+2:0]  bits;

   assign big  = ({1'b0, cnt} >= (IMM_W+1)'(NB));
   assign bits = {cnt, 3'b000};
   assign res  = big   ? '0 :
                 right ? (a >> bits) : (a << bits);

endmodule

// File: rtl/psimd_alu.sv
module psimd_alu #(
   parameter int W     = 128,
   parameter int IMM_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [3:0]       op,
   input  logic [1:0]       esize,
   input  logic [IMM_W-1:0] imm,
   input  logic [W-1:0]     src_a,
   input  logic [W-1:0]     src_b,
   output logic             out_valid,
   output logic [W-1:0]     result,
   output logic             illegal
);
   import psimd_pkg::*;

   localparam int NB = W / 8;

   if (W < 64 || (W % 64) != 0) begin : g_bad_width
      $error("psimd_alu: W must be a positive multiple of 64");
   end
   if ((1 << IMM_W) <= NB) begin : g_bad_imm
      $error("psimd_alu: IMM_W too narrow to express a full byte shift");
   end

   logic [W-1:0] arith_v, eq_v, lsh_v, bsh_v;
   logic [1:0]   kind;
   logic [W-1:0] res_n;
   logic         ill_n;

   always_comb begin
      case (op)
         OP_SHR:  kind = SK_RIGHT;
         OP_SAR:  kind = SK_ARITH;
         default: kind = SK_LEFT;
      endcase
   end

   psimd_lane_arith #(.W(W)) u_arith (
      .a(src_a), .b(src_b), .sub(op == OP_SUB), .sz(esize),
      .sum_o(arith_v), .eq_o(eq_v)
   );

   psimd_lane_shift #(.W(W), .IMM_W(IMM_W)) u_lshift (
      .a(src_a), .cnt(imm), .sz(esize), .kind(kind), .res(lsh_v)
   );

   psimd_byte_shift #(.W(W), .IMM_W(IMM_W)) u_bshift (
      .a(src_a), .cnt(imm), .right(op == OP_BSR), .res(bsh_v)
   );

   always_comb begin
      ill_n = 1'b0;
      res_n = '0;
      case (op)
         OP_ADD, OP_SUB: res_n = arith_v;
         OP_AND:         res_n = src_a & src_b;
         OP_OR:          res_n = src_a | src_b;
         OP_XOR:         res_n = src_a ^ src_b;
         OP_ANDN:        res_n = ~src_a & src_b;
         OP_CMPEQ:       res_n = eq_v;
         OP_SHL, OP_SHR: begin
            if (esize == SZ_8) ill_n = 1'b1;
            else               res_n = lsh_v;
         end
         OP_SAR: begin
            if (esize == SZ_8 || esize == SZ_64) ill_n = 1'b1;
            else                                 res_n = lsh_v;
         end
         OP_BSL, OP_BSR: res_n = bsh_v;
         default:        ill_n = 1'b1;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         result    <= '0;
         illegal   <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            result  <= res_n;
            illegal <= ill_n;
         end
      end
   end

   assert_valid_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   assert_valid_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   assert_hold_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(result) && $stable(illegal)));
   assert_illegal_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && illegal) |-> (result == '0));
   assert_sar_sizes_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == OP_SAR && (esize == SZ_8 || esize == SZ_64)) |=> illegal);
   assert_xor_self_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == OP_XOR && src_a == src_b) |=> (result == '0));
   assert_cmpeq_equal_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == OP_CMPEQ && src_a == src_b) |=> (result == '1));
   assert_byte_overrun_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (op == OP_BSL || op == OP_BSR) && {1'b0, imm} >= (IMM_W+1)'(NB))
      |=> (result == '0 && !illegal));

endmodule

// File: tb/psimd_alu_tb.sv
`timescale 1ns/1ps
module psimd_alu_tb;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [3:0]   op = '0;
   logic [1:0]   esize = '0;
   logic [7:0]   imm = '0;
   logic [127:0] src_a = '0, src_b = '0;
   logic         out_valid;
   logic [127:0] result;
   logic         illegal;

   int n_checks = 0;
   int n_errors = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   psimd_alu u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .esize(esize),
      .imm(imm), .src_a(src_a), .src_b(src_b),
      .out_valid(out_valid), .result(result), .illegal(illegal)
   );

   typedef struct {
      logic [127:0] r;
      logic         ill;
      string        tag;
   } exp_t;

   exp_t exp_q[$];
   exp_t last_e;
   bit   have_last = 1'b0;

   function automatic string tag_of(input logic [3:0] o, input logic il);
      if (il) return "R7";
      case (o)
         4'd0: return "R1";
         4'd1: return "R2";
         4'd2, 4'd3, 4'd4, 4'd5: return "R3";
         4'd6: return "R4";
         4'd7, 4'd8: return "R5";
         4'd9: return "R6";
         default: return "R8";
      endcase
   endfunction

   function automatic void model(input logic [3:0] o, input logic [1:0] sz,
                                 input logic [7:0] im, input logic [127:0] a,
                                 input logic [127:0] b, output logic [127:0] r,
                                 output logic il);
      int ew, nl;
      logic [63:0] m, ea, eb, e, sx;
      ew = 8 << sz;
      nl = 128 / ew;
      m  = (ew == 64) ? '1 : ((64'd1 << ew) - 64'd1);
      r  = '0;
      case (o)
         4'd7, 4'd8: il = (sz == 2'd0);
         4'd9:       il = (sz == 2'd0 || sz == 2'd3);
         4'd12, 4'd13, 4'd14, 4'd15: il = 1'b1;
         default:    il = 1'b0;
      endcase
      if (il) return;
      case (o)
         4'd2: r = a & b;
         4'd3: r = a | b;
         4'd4: r = a ^ b;
         4'd5: r = (~a) & b;
         4'd10: r = (im >= 8'd16) ? '0 : (a << (int'(im) * 8));
         4'd11: r = (im >= 8'd16) ? '0 : (a >> (int'(im) * 8));
         default: begin
            for (int l = 0; l < nl; l++) begin
               ea = 64'(a >> (l * ew)) & m;
               eb = 64'(b >> (l * ew)) & m;
               sx = ea[ew-1] ? (ea | ~m) : ea;
               case (o)
                  4'd0: e = ea + eb;
                  4'd1: e = ea - eb;
                  4'd6: e = (ea == eb) ? m : '0;
                  4'd7: e = (int'(im) >= ew) ? '0 : (ea << im);
                  4'd8: e = (int'(im) >= ew) ? '0 : (ea >> im);
                  default: e = (int'(im) >= ew) ? (ea[ew-1] ? m : '0)
                                                : 64'($signed(sx) >>> im);
               endcase
               r = r | (128'(e & m) << (l * ew));
            end
         end
      endcase
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [127:0] act, input logic [127:0] expv);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
      end
   endtask

   task automatic send(input logic [3:0] o, input logic [1:0] sz, input logic [7:0] im,
                       input logic [127:0] a, input logic [127:0] b);
      exp_t e;
      @(negedge clk);
      op = o; esize = sz; imm = im; src_a = a; src_b = b; in_valid = 1'b1;
      model(o, sz, im, a, b, e.r, e.ill);
      e.tag = tag_of(o, e.ill);
      exp_q.push_back(e);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
      end
   endtask

   // Monitor: result is due at the falling edge after the capturing rising edge.
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         if (out_valid) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R9", "out_valid without request", 128'(out_valid), '0);
            end else begin
               exp_t e;
               e = exp_q.pop_front();
               check(result == e.r, e.tag, "result", result, e.r);
               check(illegal == e.ill, e.tag, "illegal flag", 128'(illegal), 128'(e.ill));
               last_e = e;
               have_last = 1'b1;
            end
         end else if (have_last) begin
            check(result == last_e.r && illegal == last_e.ill, "R9",
                  "hold while idle", result, last_e.r);
         end
      end
   end

   initial begin
      #(8 * 200000);
      if (!finished) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual=running expected=done");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   function automatic logic [127:0] rnd128();
      return {$urandom, $urandom, $urandom, $urandom};
   endfunction

   initial begin
      logic [127:0] ones, pat, neg;
      ones = '1;
      repeat (3) @(negedge clk);
      check(out_valid == 1'b0 && result == '0 && illegal == 1'b0, "R10",
            "reset state", result, '0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(out_valid == 1'b0, "R9", "idle after reset", 128'(out_valid), '0);

      pat = 128'h8000_7FFF_0123_4567_89AB_CDEF_FEDC_BA98;
      neg = 128'hF000_8001_7FFF_0004_8000_0001_C000_1234;
      // R1/R2: carry and borrow must stay inside each lane
      for (int s = 0; s < 4; s++) begin
         send(4'd0, 2'(s), 8'd0, ones, {16{8'h01}});
         send(4'd1, 2'(s), 8'd0, '0, {16{8'h01}});
         send(4'd0, 2'(s), 8'd0, pat, neg);
      end
      idle(2);
      // R3 bitwise and XOR self-zeroing
      send(4'd2, 2'd0, 8'd0, pat, neg);
      send(4'd3, 2'd3, 8'd0, pat, neg);
      send(4'd4, 2'd1, 8'd0, pat, pat);
      send(4'd5, 2'd2, 8'd0, pat, neg);
      // R4 compare: some lanes equal
      send(4'd6, 2'd1, 8'd0, pat, pat ^ 128'h0000_0000_0000_0001_0000_0000_0000_0000);
      send(4'd6, 2'd0, 8'd0, pat, pat);
      // R5/R6 shift counts at and around lane width
      for (int s = 1; s < 4; s++) begin
         for (int c = 0; c < 3; c++) begin
            logic [7:0] cn;
            cn = (c == 0) ? 8'd3 : (c == 1) ? 8'((8 << s) - 1) : 8'(8 << s);
            send(4'd7, 2'(s), cn, neg, '0);
            send(4'd8, 2'(s), cn, neg, '0);
            send(4'd9, 2'(s), cn, neg, '0);
         end
      end
      idle(3);
      // R7 illegal requests
      send(4'd7, 2'd0, 8'd1, pat, neg);
      send(4'd8, 2'd0, 8'd1, pat, neg);
      send(4'd9, 2'd0, 8'd1, pat, neg);
      send(4'd9, 2'd3, 8'd1, pat, neg);
      send(4'd12, 2'd1, 8'd0, pat, neg);
      send(4'd15, 2'd2, 8'd0, pat, neg);
      // R8 byte shifts
      send(4'd10, 2'd0, 8'd5, pat, '0);
      send(4'd11, 2'd0, 8'd5, pat, '0);
      send(4'd10, 2'd2, 8'd15, pat, '0);
      send(4'd11, 2'd1, 8'd16, pat, '0);
      send(4'd10, 2'd3, 8'd200, pat, '0);
      idle(2);
      // Mixed random traffic with idle gaps
      for (int i = 0; i < 400; i++) begin
         logic [127:0] a, b;
         logic [7:0] im;
         a = rnd128();
         case ($urandom % 3)
            0: b = a;
            1: b = a ^ ({4{$urandom}} & {4{32'h00FF_0000}});
            default: b = rnd128();
         endcase
         im = (($urandom % 8) == 0) ? 8'($urandom) : 8'($urandom % 72);
         send(4'($urandom), 2'($urandom), im, a, b);
         if (($urandom % 5) == 0) idle(1 + ($urandom % 2));
      end
      idle(4);
      check(exp_q.size() == 0, "R9", "all results delivered",
            128'(exp_q.size()), '0);
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule